// File: doc/BRIEF.md
# Decode-Stage Register File with Write-Back Forwarding

This block holds the architectural registers read by the decode stage of a five-stage pipeline. It has two read ports and one write port. All of them act on the rising clock edge. The write port is driven by the write-back stage. The storage array only takes that write at the end of the current cycle, so a decode-stage read of the same register in the same cycle would see the old contents.

To prevent this, each read port compares its address with the write-back address. On a match with the write enabled, the port returns the incoming write data instead of the stored word. Read results are registered, so there is one cycle of latency. Register 0 is hard-wired to zero. The register count and the word width are parameters, with defaults of 32 and 32.

Top module: `rf_fwd2r1w`

## Requirements
- R1: While reset is asserted, both read outputs become zero and every register is cleared to zero. After reset is released, any register read before it is written returns zero.
- R2: A read address presented before a rising edge produces that register's contents on its read output right after the edge. The contents include every write taken at earlier edges.
- R3: Register 0 always reads as zero. A write to register 0 has no effect, and it is never forwarded to a read port.
- R4: When the write enable is high and a read port's address equals a nonzero write address at the same edge, that port returns the write data presented at that edge.
- R5: When the write enable is low, a read port returns the stored contents even if its address equals the write address.
- R6: The two read ports are independent. They may read the same or different registers at the same edge, and both may forward the write data at once.
- R7: A write with the enable low leaves the addressed register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_en | input | 1 | Write-back enable |
| wb_addr | input | $clog2(NREGS) | Write-back register index |
| wb_data | input | WIDTH | Write-back data |
| ra_addr | input | $clog2(NREGS) | Read port A index |
| ra_data | output | WIDTH | Read port A data, one cycle after address |
| rb_addr | input | $clog2(NREGS) | Read port B index |
| rb_data | output | WIDTH | Read port B data, one cycle after address |

## Verification
A write-back and a read of the same register can occur at the same edge. In that case the forwarding path must win over the stale array entry.

The bench forces this overlap on each port alone and on both ports together. It repeats the overlap with the enable low and with register 0 as the target. It then mixes in random traffic over a narrow address range so that matches are frequent.

Each read result is compared against a bench model. The model applies the forwarding rule at the edge and commits the write only afterwards.

// File: rtl/rf_fwd2r1w.sv
module rf_fwd2r1w #(
  parameter int NREGS = 32,
  parameter int WIDTH = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wb_en,
  input  logic [$clog2(NREGS)-1:0] wb_addr,
  input  logic [WIDTH-1:0]         wb_data,
  input  logic [$clog2(NREGS)-1:0] ra_addr,
  output logic [WIDTH-1:0]         ra_data,
  input  logic [$clog2(NREGS)-1:0] rb_addr,
  output logic [WIDTH-1:0]         rb_data
);
  localparam int AW = $clog2(NREGS);
  localparam int NRD = 2;

  logic [WIDTH-1:0] regs [NREGS];
  logic [AW-1:0]    rd_addr [NRD];
  logic [WIDTH-1:0] rd_q    [NRD];
  logic             wr_live;

  assign wr_live    = wb_en && (wb_addr != '0);
  assign rd_addr[0] = ra_addr;
  assign rd_addr[1] = rb_addr;
  assign ra_data    = rd_q[0];
  assign rb_data    = rd_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (wr_live) begin
      regs[wb_addr] <= wb_data;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    logic hit;
    assign hit = wr_live && (wb_addr == rd_addr[g]);

    always_ff @(posedge clk) begin
      if (!rst_n)                  rd_q[g] <= '0;
      else if (rd_addr[g] == '0)   rd_q[g] <= '0;
      else if (hit)                rd_q[g] <= wb_data;
      else                         rd_q[g] <= regs[rd_addr[g]];
    end

    AST_ZERO_REG: assert property (@(posedge clk) disable iff (!rst_n)
      rd_addr[g] == '0 |=> rd_q[g] == '0); // R3

    AST_FWD_WIN: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en && wb_addr != '0 && wb_addr == rd_addr[g]) |=> rd_q[g] == $past(wb_data)); // R4

    AST_WRITE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(wb_en) && $past(wb_addr) != '0 && !wb_en
       && rd_addr[g] == $past(wb_addr)) |=> rd_q[g] == $past(wb_data, 2)); // R2
  end

  AST_RESET_CLR: assert property (@(posedge clk)
    !rst_n |=> (ra_data == '0 && rb_data == '0)); // R1
endmodule

// File: tb/rf_fwd2r1w_tb.sv
module rf_fwd2r1w_tb;
  localparam int NREGS = 32;
  localparam int WIDTH = 32;
  localparam int AW = $clog2(NREGS);

  logic clk = 0;
  logic rst_n = 0;
  logic wb_en = 0;
  logic [AW-1:0] wb_addr = '0, ra_addr = '0, rb_addr = '0;
  logic [WIDTH-1:0] wb_data = '0;
  logic [WIDTH-1:0] ra_data, rb_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [WIDTH-1:0] model [NREGS];

  always #2.5 clk = ~clk;

  rf_fwd2r1w #(.NREGS(NREGS), .WIDTH(WIDTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
    .ra_addr(ra_addr), .ra_data(ra_data), .rb_addr(rb_addr), .rb_data(rb_data));

  function automatic logic [WIDTH-1:0] expect_rd(logic [AW-1:0] a, logic en,
                                                 logic [AW-1:0] wa, logic [WIDTH-1:0] wd);
    if (a == '0) return '0;
    if (en && wa == a) return wd;
    return model[a];
  endfunction

  task automatic check(string tag, string port, logic [WIDTH-1:0] act, logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s port %s: actual %h expected %h", tag, port, act, exp);
    end
  endtask

  task automatic step(string tag, logic en, logic [AW-1:0] wa, logic [WIDTH-1:0] wd,
                      logic [AW-1:0] a, logic [AW-1:0] b);
    logic [WIDTH-1:0] ea, eb;
    @(negedge clk);
    wb_en = en; wb_addr = wa; wb_data = wd; ra_addr = a; rb_addr = b;
    ea = expect_rd(a, en, wa, wd);
    eb = expect_rd(b, en, wa, wd);
    if (en && wa != '0) model[wa] = wd;
    @(posedge clk);
    #1;
    check(tag, "A", ra_data, ea);
    check(tag, "B", rb_data, eb);
  endtask

  initial begin
    #900000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1234);
    for (int i = 0; i < NREGS; i++) model[i] = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "A", ra_data, '0);
    check("R1", "B", rb_data, '0);
    @(negedge clk); rst_n = 1;

    // R1: unwritten registers read zero after reset
    for (int i = 1; i < NREGS; i += 2) step("R1", 0, '0, '0, AW'(i), AW'(i + 1 < NREGS ? i + 1 : 0));

    // R2: write then read back
    step("R2", 1, 5'd3, 32'hDEADBEEF, 5'd1, 5'd2);
    step("R2", 1, 5'd9, 32'h12345678, 5'd3, 5'd4);
    step("R2", 0, '0, '0, 5'd9, 5'd3);

    // R3: writes to register 0 are dropped and not forwarded
    step("R3", 1, 5'd0, 32'hFFFFFFFF, 5'd0, 5'd0);
    step("R3", 0, '0, '0, 5'd0, 5'd0);

    // R4: same-edge forwarding on each port
    step("R4", 1, 5'd7, 32'hA5A5A5A5, 5'd7, 5'd3);
    step("R4", 1, 5'd8, 32'h5A5A5A5A, 5'd9, 5'd8);

    // R5/R7: enable low on a matching address returns stored value, no update
    step("R5", 0, 5'd7, 32'h11111111, 5'd7, 5'd7);
    step("R7", 0, '0, '0, 5'd7, 5'd8);

    // R6: both ports forward together, then different registers at once
    step("R6", 1, 5'd12, 32'hCAFEF00D, 5'd12, 5'd12);
    step("R6", 1, 5'd13, 32'h0BADC0DE, 5'd12, 5'd13);
    step("R6", 0, '0, '0, 5'd13, 5'd12);

    // R2: random traffic with a narrow address range
    for (int n = 0; n < 2000; n++) begin
      logic [AW-1:0] wa, a, b;
      logic en;
      if ($urandom_range(0, 3) == 0) begin
        wa = AW'($urandom_range(0, NREGS - 1));
        a  = AW'($urandom_range(0, NREGS - 1));
        b  = AW'($urandom_range(0, NREGS - 1));
      end else begin
        wa = AW'($urandom_range(0, 5));
        a  = AW'($urandom_range(0, 5));
        b  = AW'($urandom_range(0, 5));
      end
      en = ($urandom_range(0, 3) != 0);
      step("R2", en, wa, $urandom, a, b);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule